// File: doc/BRIEF.md
# I2C Register Target

This block is a slave-only I2C target that gives a bus master read and write access to a bank of 8-bit control registers. The registers sit outside the block. The block reaches them through an internal pointer that the master loads with a subaddress byte. SCL is only an input. For SDA the block takes the sampled bus level and returns a drive-low enable, so the board's pull-up sets the released level. A strap input supplies the least significant bit of the 7-bit device address. Two targets can therefore share one bus.

A write is a START, the device address with R/W clear, the subaddress byte, and then any number of data bytes, ending with a STOP. A read is the same address and subaddress phase, followed by a repeated START, the device address with R/W set, and then data bytes sent by the target. The master ACKs every read byte except the last, which it NAKs. After each data byte the pointer advances by one, in both directions, so a burst covers consecutive registers.

The register file is expected to answer combinationally. `rd_data` must reflect `reg_idx` in the same clock cycle as `rd_stb`.

Top module: `i2c_reg_target`

## Requirements
- R1: The block ACKs an address byte whose upper seven bits equal 1011100 with bit 1 replaced by the strap level (8'hB8/8'hB9 with the strap low, 8'hBA/8'hBB with it high; bit 0 is R/W, 0 = write). An ACK is SDA held low during the ninth SCL high phase.
- R2: The strap is used live. The comparison at each address phase uses the strap level present at that moment.
- R3: On an address mismatch the block sends no ACK. It also sends no ACK and makes no register access for any further byte until the next START.
- R4: The block only ever pulls SDA low, never drives SCL, and changes its SDA drive only while SCL is low.
- R5: In a write, the block ACKs the address, the subaddress and every data byte.
- R6: Each fully received data byte raises `wr_stb` for exactly one clock cycle. During that cycle `reg_idx` holds the pointer and `wr_data` holds the byte, which arrives MSB first and is sampled on rising SCL. The strobe comes before the ACK for that byte is driven.
- R7: The pointer advances by one after every data byte in either direction and wraps from 8'hFF to 8'h00.
- R8: After a repeated START with R/W set, the block sends register contents MSB first, starting at the subaddress written before the restart. `rd_stb` pulses once per byte, at the moment the byte is loaded for sending.
- R9: A master NAK ends the read. The block releases SDA and raises no further `rd_stb`.
- R10: A START or STOP at any bit position abandons the byte in progress. After a START, a new address phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 1 | Device address bit 0 |
| reg_idx | output | 8 | Register index, equal to the pointer |
| wr_data | output | 8 | Byte to write |
| wr_stb | output | 1 | One-cycle register write strobe |
| rd_stb | output | 1 | One-cycle register read strobe |
| rd_data | input | 8 | Register contents at `reg_idx` |

## Verification
The assertions assume that the master changes SDA only while SCL is low, outside START and STOP. They also assume that every SCL level lasts longer than the synchronizer delay, so the block has seen SCL fall before it moves its own drive. The stimulus holds each quarter bit for eight clocks and changes master SDA only in the SCL-low window. The one exception is the deliberate START and STOP edges, which are issued with SCL held high. Random bursts vary the subaddress, the length and the data. Directed cases cover strap changes, mismatched addresses, pointer wrap, and conditions that arrive mid-byte.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [5:0] ADDR_HI = 6'b101110,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic       addr_strap,
  output logic [7:0] reg_idx,
  output logic [7:0] wr_data,
  output logic       wr_stb,
  output logic       rd_stb,
  input  logic [7:0] rd_data
);
  localparam int TOP = SYNC_STAGES;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_SUB, ST_SUB_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_RD_NEXT, ST_SKIP
  } state_t;

  state_t     state;
  logic [TOP:0] scl_sh, sda_sh;
  logic [7:0] sh, ptr;
  logic [3:0] cnt;
  logic       rw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_i};
      sda_sh <= {sda_sh[TOP-1:0], sda_i};
    end

  wire scl    = scl_sh[TOP-1];
  wire scl_d  = scl_sh[TOP];
  wire sda    = sda_sh[TOP-1];
  wire sda_d  = sda_sh[TOP];
  wire scl_hi = scl & scl_d;
  wire start  = scl_hi & sda_d & ~sda;
  wire stop   = scl_hi & ~sda_d & sda;
  wire rise   = scl & ~scl_d;
  wire fall   = ~scl & scl_d;

  wire [7:0] rx_byte = {sh[6:0], sda};
  wire       byte_in = rise && cnt == 4'd7;
  wire       hit     = rx_byte[7:1] == {ADDR_HI, addr_strap};

  assign reg_idx = ptr;
  assign wr_data = rx_byte;
  assign wr_stb  = !start && !stop && state == ST_WR && byte_in;
  assign rd_stb  = !start && !stop && fall &&
                   ((state == ST_DEV_ACK && sda_pull && rw) || state == ST_RD_NEXT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_IDLE;
      sh       <= '0;
      ptr      <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start) begin
      state    <= ST_DEV;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      if (rd_stb) begin
        sh       <= rd_data;
        sda_pull <= ~rd_data[7];
        ptr      <= ptr + 8'd1;
        cnt      <= '0;
        state    <= ST_RD;
      end else begin
        case (state)
          ST_DEV, ST_SUB, ST_WR:
            if (rise) begin
              sh  <= rx_byte;
              cnt <= cnt + 4'd1;
              if (byte_in) begin
                cnt <= '0;
                case (state)
                  ST_DEV: if (hit) begin
                    rw    <= rx_byte[0];
                    state <= ST_DEV_ACK;
                  end else state <= ST_SKIP;
                  ST_SUB: begin
                    ptr   <= rx_byte;
                    state <= ST_SUB_ACK;
                  end
                  default: begin
                    ptr   <= ptr + 8'd1;
                    state <= ST_WR_ACK;
                  end
                endcase
              end
            end
          ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK:
            if (fall) begin
              if (!sda_pull) sda_pull <= 1'b1;
              else begin
                sda_pull <= 1'b0;
                cnt      <= '0;
                state    <= (state == ST_DEV_ACK) ? ST_SUB : ST_WR;
              end
            end
          ST_RD: begin
            if (rise) cnt <= cnt + 4'd1;
            if (fall) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                sh       <= {sh[6:0], 1'b0};
                sda_pull <= ~sh[6];
              end
            end
          end
          ST_RD_ACK:
            if (rise) state <= sda ? ST_SKIP : ST_RD_NEXT;
          default: ;
        endcase
      end
    end

  // R4
  pull_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl));

  // R6
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));

  // R6
  wr_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !sda_pull);

  // R7
  wr_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> reg_idx == $past(reg_idx) + 8'd1);

  // R7
  rd_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> reg_idx == $past(reg_idx) + 8'd1);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && sda_d && !sda) |=> !sda_pull && !wr_stb && !rd_stb);
endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic sda_pull, wr_stb, rd_stb;
  logic [7:0] reg_idx, wr_data, rd_data;
  wire sda_bus = m_sda & ~sda_pull;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int checks = 0, errors = 0, we_cnt, re_cnt, oe_bad;
  logic oe_q = 1'b0;
  bit done = 0;

  i2c_reg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull(sda_pull),
    .addr_strap(strap), .reg_idx(reg_idx), .wr_data(wr_data), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .rd_data(rd_data)
  );

  assign rd_data = mem[reg_idx];

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [7:0] dev(logic s, logic r);
    return {6'b101110, s, r};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      we_cnt <= 0; re_cnt <= 0; oe_bad <= 0;
    end else begin
      if (wr_stb) begin mem[reg_idx] <= wr_data; we_cnt <= we_cnt + 1; end
      if (rd_stb) re_cnt <= re_cnt + 1;
      if (sda_pull !== oe_q && m_scl) oe_bad <= oe_bad + 1;
    end
    oe_q <= sda_pull;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); ack = !sda_bus; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic recv_byte(bit nak, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); d[i] = sda_bus; qw(); m_scl = 1'b0; qw();
    end
    m_sda = nak; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic write_regs(logic [7:0] da, logic [7:0] sub, int n, output int nacks);
    bit a;
    nacks = 0;
    i2c_start();
    send_byte(da, a); if (!a) nacks++;
    send_byte(sub, a); if (!a) nacks++;
    for (int k = 0; k < n; k++) begin send_byte(wbuf[k], a); if (!a) nacks++; end
    i2c_stop();
  endtask

  task automatic read_regs(logic s, logic [7:0] sub, int n, output int nacks);
    bit a;
    nacks = 0;
    i2c_start();
    send_byte(dev(s, 1'b0), a); if (!a) nacks++;
    send_byte(sub, a); if (!a) nacks++;
    i2c_start();
    send_byte(dev(s, 1'b1), a); if (!a) nacks++;
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    qw();
    chk(sda_pull == 1'b0, "R9 released after NAK", sda_pull, 0);
    i2c_stop();
  endtask

  task automatic do_write(logic [7:0] sub, int n, string req);
    int na, w0;
    w0 = we_cnt;
    write_regs(dev(strap, 1'b0), sub, n, na);
    chk(na == 0, {req, " R5 all bytes ACKed"}, na, 0);
    chk(we_cnt - w0 == n, {req, " R6 one strobe per byte"}, we_cnt - w0, n);
    for (int k = 0; k < n; k++) exp_mem[8'(sub + k)] = wbuf[k];
    for (int k = 0; k < n; k++)
      chk(mem[8'(sub + k)] == exp_mem[8'(sub + k)], {req, " R7 write lands"},
          mem[8'(sub + k)], exp_mem[8'(sub + k)]);
  endtask

  task automatic do_read(logic [7:0] sub, int n, string req);
    int na, r0;
    r0 = re_cnt;
    read_regs(strap, sub, n, na);
    chk(na == 0, {req, " R8 address phases ACKed"}, na, 0);
    chk(re_cnt - r0 == n, {req, " R9 read strobes"}, re_cnt - r0, n);
    for (int k = 0; k < n; k++)
      chk(rbuf[k] == exp_mem[8'(sub + k)], {req, " R8 data"}, rbuf[k], exp_mem[8'(sub + k)]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int na, w0, r0;
    bit a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_pull == 0 && wr_stb == 0 && rd_stb == 0, "R4 reset idle",
        {sda_pull, wr_stb, rd_stb}, 0);

    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    do_write(8'h10, 2, "R1 basic");
    do_read(8'h10, 2, "R8 basic");

    // R2: strap high moves the address
    strap = 1'b1;
    w0 = we_cnt;
    write_regs(dev(1'b0, 1'b0), 8'h20, 1, na);
    chk(na == 3, "R2 old address NAKed with strap high", na, 3);
    chk(we_cnt == w0, "R3 no write on mismatch", we_cnt, w0);
    wbuf[0] = 8'h77;
    do_write(8'h20, 1, "R2 strap high");
    do_read(8'h20, 1, "R2 strap high");
    strap = 1'b0;

    // R3: unrelated address
    w0 = we_cnt; r0 = re_cnt;
    write_regs(8'hB4, 8'h30, 2, na);
    chk(na == 4, "R3 mismatch NAKs all bytes", na, 4);
    chk(we_cnt == w0 && re_cnt == r0, "R3 no register access", we_cnt + re_cnt, w0 + r0);

    // R7: wrap on write and read
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    do_write(8'hFE, 3, "R7 wrap");
    do_read(8'hFF, 2, "R7 wrap");

    // R10: START mid-byte, then a valid write
    i2c_start();
    send_bits(8'hA0, 3);
    wbuf[0] = 8'h9E;
    do_write(8'h40, 1, "R10 restart mid-byte");

    // R10: STOP mid-data-byte leaves register untouched
    w0 = we_cnt;
    i2c_start();
    send_byte(dev(1'b0, 1'b0), a);
    send_byte(8'h40, a);
    send_bits(8'hFF, 4);
    i2c_stop();
    chk(we_cnt == w0, "R10 stop mid-byte no write", we_cnt, w0);
    do_read(8'h40, 1, "R10 after stop");

    // Random bursts
    for (int t = 0; t < 24; t++) begin
      logic [7:0] sub;
      int n;
      sub = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(sub, n, "R6 random");
      do_read(sub, 1 + int'($urandom % n), "R8 random");
    end

    chk(oe_bad == 0, "R4 SDA drive changed with SCL high", oe_bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule